// File: doc/BRIEF.md
# Floating-Point Exception Recorder and Trap Decision

This block sits at the end of a floating-point operation. It takes the five IEEE exception flags raised by the operation and the current 64-bit floating-point status word. It then works out the next status word and whether a trap is taken. It also produces the next program-counter pair. Enabled exceptions cause a trap. When a trap is taken, the cause is narrowed to one flag by a fixed priority, and the accumulated-history field is left alone. When no trap is taken, the raised flags are recorded in both the per-operation field and the history field, and the PC pair moves one instruction forward.

Results are registered. On a clock edge where `rec_valid_i` is high, the outputs load the new status, trap bit and PC pair. On every other edge they hold their values. Delivering the trap is the job of the surrounding logic.

Flag bit order, used everywhere in the block:
- invalid = bit 4
- overflow = bit 3
- underflow = bit 2
- divide-by-zero = bit 1
- inexact = bit 0

Top module: `fpx_recorder`

## Requirements
- R1: While `rst_n` is low, `stat_o`, `trap_o`, `pc_o` and `npc_o` are all zero.
- R2: On a clock edge with `rec_valid_i` high, `trap_o` becomes 1 exactly when the bitwise AND of `flags_i` and the enable field (`stat_i[27:23]`, flag order as above) is nonzero. Otherwise it becomes 0.
- R3: On a trapping update, `stat_o[4:0]` holds a single flag. That flag is the highest-priority bit of the enabled raised flags. Priority runs invalid (bit 4), then overflow (3), then underflow (2), then divide-by-zero (1), then inexact (0). Raised flags that are not enabled never appear.
- R4: On a non-trapping update, `stat_o[4:0]` equals `flags_i`, and `stat_o[9:5]` equals `stat_i[9:5] | flags_i`.
- R5: On a trapping update, `stat_o[9:5]` equals `stat_i[9:5]` and `stat_o[14]` is 1.
- R6: On a non-trapping update, `pc_o` takes `npc_i` and `npc_o` takes `npc_i + 4` modulo 2^64. On a trapping update, `pc_o` takes `pc_i` and `npc_o` takes `npc_i`.
- R7: An update with `flags_i` all zero clears `stat_o[4:0]`, leaves the history field equal to `stat_i[9:5]`, does not trap, and advances the PC pair.
- R8: On every update, each status bit outside 4:0 and 9:5 is copied from `stat_i`. The one exception is bit 14, which is forced to 1 when trapping.
- R9: On a clock edge with `rec_valid_i` low, all outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid_i | input | 1 | Operation completed; record its flags on this edge |
| flags_i | input | 5 | Raised IEEE flags: invalid, overflow, underflow, divide-by-zero, inexact (bits 4 to 0) |
| stat_i | input | 64 | Current status word |
| pc_i | input | 64 | PC of the completed instruction |
| npc_i | input | 64 | Next PC of the completed instruction |
| stat_o | output | 64 | Registered next status word |
| trap_o | output | 1 | Registered trap decision |
| pc_o | output | 64 | Registered next PC |
| npc_o | output | 64 | Registered next NPC |

## Verification
The trap decision and the history accumulation both act on the same flag vector in the same cycle. A flag vector that mixes enabled and disabled flags therefore exercises both at once. The bench provokes this by raising all five flags while only the two lowest-priority ones are enabled. It then judges that exactly one enabled flag appears as the cause, that the disabled flags reach neither field, and that the PC pair holds. The reverse case, where disabled flags are raised with nothing enabled, must accrue those flags and advance the PC pair.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int unsigned FPX_FLAG_W  = 5;
   localparam int unsigned FPX_WORD_W  = 64;
   localparam int unsigned FPX_ADDR_W  = 64;

   // flag positions inside the flag vector (also the priority order)
   localparam int unsigned FPX_NV = 4;
   localparam int unsigned FPX_OF = 3;
   localparam int unsigned FPX_UF = 2;
   localparam int unsigned FPX_DZ = 1;
   localparam int unsigned FPX_NX = 0;

   // status word field placement
   localparam int unsigned FPX_ENA_LSB  = 23;
   localparam int unsigned FPX_HIST_LSB = 5;
   localparam int unsigned FPX_CUR_LSB  = 0;
   localparam int unsigned FPX_TTYP_BIT = 14;

   localparam int unsigned FPX_PC_STEP  = 4;

   typedef logic [FPX_FLAG_W-1:0] fpx_flags_t;
endpackage

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide #(
   parameter int unsigned FLAG_W = 5
) (
   input  logic [FLAG_W-1:0] raised_i,
   input  logic [FLAG_W-1:0] enable_i,
   output logic [FLAG_W-1:0] armed_o,
   output logic              take_o
);
   always_comb begin
      armed_o = raised_i & enable_i;
      take_o  = |armed_o;
   end
endmodule

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
   parameter int unsigned FLAG_W   = 5,
   parameter bit          HIGH_WIN = 1'b1
) (
   input  logic [FLAG_W-1:0] req_i,
   output logic [FLAG_W-1:0] pick_o
);
   logic [FLAG_W:0] seen;

   generate
      if (HIGH_WIN) begin : g_top_down
         assign seen[FLAG_W] = 1'b0;
         for (genvar i = FLAG_W; i > 0; i--) begin : g_bit
            assign pick_o[i-1] = req_i[i-1] & ~seen[i];
            assign seen[i-1]   = seen[i] | req_i[i-1];
         end
      end else begin : g_bottom_up
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
            assign pick_o[i] = req_i[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req_i[i];
         end
      end
   endgenerate

   logic unused_tail;
   generate
      if (HIGH_WIN) begin : g_tail_hi
         assign unused_tail = seen[0];
      end else begin : g_tail_lo
         assign unused_tail = seen[FLAG_W];
      end
   endgenerate
   logic unused_ok;
   assign unused_ok = unused_tail;
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge #(
   parameter int unsigned WORD_W   = 64,
   parameter int unsigned FLAG_W   = 5,
   parameter int unsigned HIST_LSB = 5,
   parameter int unsigned CUR_LSB  = 0,
   parameter int unsigned TTYP_BIT = 14
) (
   input  logic [WORD_W-1:0] stat_i,
   input  logic [FLAG_W-1:0] raised_i,
   input  logic [FLAG_W-1:0] cause_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] stat_o
);
   logic [FLAG_W-1:0] cur_new;
   logic [FLAG_W-1:0] hist_new;

   always_comb begin
      cur_new  = take_i ? cause_i : raised_i;
      hist_new = stat_i[HIST_LSB +: FLAG_W] | (take_i ? '0 : raised_i);
      stat_o   = stat_i;
      stat_o[CUR_LSB  +: FLAG_W] = cur_new;
      stat_o[HIST_LSB +: FLAG_W] = hist_new;
      if (take_i) begin
         stat_o[TTYP_BIT] = 1'b1;
      end
   end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned STEP   = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] npc_i,
   input  logic              hold_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_comb begin
      if (hold_i) begin
         pc_o  = pc_i;
         npc_o = npc_i;
      end else begin
         pc_o  = npc_i;
         npc_o = npc_i + STEP_V;
      end
   end
endmodule

// File: rtl/fpx_recorder.sv
module fpx_recorder
   import fpx_pkg::*;
#(
   parameter int unsigned WORD_W   = FPX_WORD_W,
   parameter int unsigned FLAG_W   = FPX_FLAG_W,
   parameter int unsigned ADDR_W   = FPX_ADDR_W,
   parameter int unsigned ENA_LSB  = FPX_ENA_LSB,
   parameter int unsigned HIST_LSB = FPX_HIST_LSB,
   parameter int unsigned CUR_LSB  = FPX_CUR_LSB,
   parameter int unsigned TTYP_BIT = FPX_TTYP_BIT,
   parameter int unsigned PC_STEP  = FPX_PC_STEP,
   parameter bit          HIGH_WIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_valid_i,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic [WORD_W-1:0] stat_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] npc_i,
   output logic [WORD_W-1:0] stat_o,
   output logic              trap_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o
);
   localparam int unsigned ENA_MSB  = ENA_LSB  + FLAG_W - 1;
   localparam int unsigned HIST_MSB = HIST_LSB + FLAG_W - 1;
   localparam int unsigned CUR_MSB  = CUR_LSB  + FLAG_W - 1;

   // elaboration-time parameter checks
   generate
      if (FLAG_W == 0) begin : g_bad_flag_w
         $error("FLAG_W must be nonzero");
      end
      if (ENA_MSB >= WORD_W || HIST_MSB >= WORD_W || CUR_MSB >= WORD_W) begin : g_bad_fit
         $error("status fields exceed WORD_W");
      end
      if (TTYP_BIT >= WORD_W) begin : g_bad_ttyp
         $error("TTYP_BIT outside status word");
      end
      if (!(HIST_LSB > CUR_MSB || CUR_LSB > HIST_MSB)) begin : g_bad_ovl_a
         $error("history and current fields overlap");
      end
      if (!(ENA_LSB > HIST_MSB || HIST_LSB > ENA_MSB)) begin : g_bad_ovl_b
         $error("enable and history fields overlap");
      end
      if (!(ENA_LSB > CUR_MSB || CUR_LSB > ENA_MSB)) begin : g_bad_ovl_c
         $error("enable and current fields overlap");
      end
      if ((TTYP_BIT >= CUR_LSB  && TTYP_BIT <= CUR_MSB) ||
          (TTYP_BIT >= HIST_LSB && TTYP_BIT <= HIST_MSB) ||
          (TTYP_BIT >= ENA_LSB  && TTYP_BIT <= ENA_MSB)) begin : g_bad_ovl_d
         $error("trap-type bit inside a flag field");
      end
      if (PC_STEP == 0) begin : g_bad_step
         $error("PC_STEP must be nonzero");
      end
   endgenerate

   logic [FLAG_W-1:0] armed;
   logic [FLAG_W-1:0] cause;
   logic              take;
   logic [WORD_W-1:0] stat_nx;
   logic [ADDR_W-1:0] pc_nx;
   logic [ADDR_W-1:0] npc_nx;

   fpx_trap_decide #(.FLAG_W(FLAG_W)) u_decide (
      .raised_i (flags_i),
      .enable_i (stat_i[ENA_LSB +: FLAG_W]),
      .armed_o  (armed),
      .take_o   (take)
   );

   fpx_prio_pick #(.FLAG_W(FLAG_W), .HIGH_WIN(HIGH_WIN)) u_pick (
      .req_i  (armed),
      .pick_o (cause)
   );

   fpx_status_merge #(
      .WORD_W   (WORD_W),
      .FLAG_W   (FLAG_W),
      .HIST_LSB (HIST_LSB),
      .CUR_LSB  (CUR_LSB),
      .TTYP_BIT (TTYP_BIT)
   ) u_merge (
      .stat_i   (stat_i),
      .raised_i (flags_i),
      .cause_i  (cause),
      .take_i   (take),
      .stat_o   (stat_nx)
   );

   fpx_pc_step #(.ADDR_W(ADDR_W), .STEP(PC_STEP)) u_step (
      .pc_i   (pc_i),
      .npc_i  (npc_i),
      .hold_i (take),
      .pc_o   (pc_nx),
      .npc_o  (npc_nx)
   );

   // R1 reset, R9 hold when idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_o <= '0;
         trap_o <= 1'b0;
         pc_o   <= '0;
         npc_o  <= '0;
      end else if (rec_valid_i) begin
         stat_o <= stat_nx;
         trap_o <= take;
         pc_o   <= pc_nx;
         npc_o  <= npc_nx;
      end
   end
endmodule

module fpx_record_chk #(
   parameter int unsigned WORD_W   = 64,
   parameter int unsigned FLAG_W   = 5,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned ENA_LSB  = 23,
   parameter int unsigned HIST_LSB = 5,
   parameter int unsigned CUR_LSB  = 0,
   parameter int unsigned TTYP_BIT = 14,
   parameter int unsigned PC_STEP  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rec_valid_i,
   input logic [FLAG_W-1:0] flags_i,
   input logic [WORD_W-1:0] stat_i,
   input logic [ADDR_W-1:0] pc_i,
   input logic [ADDR_W-1:0] npc_i,
   input logic [WORD_W-1:0] stat_o,
   input logic              trap_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] npc_o
);
   localparam logic [WORD_W-1:0] FLAG_ONES = WORD_W'((64'd1 << FLAG_W) - 64'd1);
   localparam logic [WORD_W-1:0] KEEP_MASK =
      ~((FLAG_ONES << CUR_LSB) | (FLAG_ONES << HIST_LSB) | (WORD_W'(1) << TTYP_BIT));
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(PC_STEP);

   logic fire;
   assign fire = (flags_i & stat_i[ENA_LSB +: FLAG_W]) != '0;

   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_valid_i |=> ($stable(stat_o) && $stable(trap_o) && $stable(pc_o) && $stable(npc_o)));

   // R2
   trap_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_i |=> (trap_o == $past(fire)));

   // R3
   single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> ($countones(stat_o[CUR_LSB +: FLAG_W]) == 1));

   // R3
   cause_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_i |=> ((stat_o[CUR_LSB +: FLAG_W] & ~$past(flags_i)) == '0));

   // R5
   trap_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> stat_o[TTYP_BIT]);

   // R5
   hist_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_i && fire) |=> (stat_o[HIST_LSB +: FLAG_W] == $past(stat_i[HIST_LSB +: FLAG_W])));

   // R6
   pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_i && !fire) |=> (pc_o == $past(npc_i) && npc_o == $past(npc_i) + STEP_V));

   // R6
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_i && fire) |=> (pc_o == $past(pc_i) && npc_o == $past(npc_i)));

   // R8
   other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_i |=> (((stat_o ^ $past(stat_i)) & KEEP_MASK) == '0));
endmodule

bind fpx_recorder fpx_record_chk #(
   .WORD_W   (WORD_W),
   .FLAG_W   (FLAG_W),
   .ADDR_W   (ADDR_W),
   .ENA_LSB  (ENA_LSB),
   .HIST_LSB (HIST_LSB),
   .CUR_LSB  (CUR_LSB),
   .TTYP_BIT (TTYP_BIT),
   .PC_STEP  (PC_STEP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rec_valid_i (rec_valid_i),
   .flags_i     (flags_i),
   .stat_i      (stat_i),
   .pc_i        (pc_i),
   .npc_i       (npc_i),
   .stat_o      (stat_o),
   .trap_o      (trap_o),
   .pc_o        (pc_o),
   .npc_o       (npc_o)
);

// File: tb/fpx_recorder_bench.sv
`timescale 1ns/1ps
module fpx_recorder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rec_valid_i = 1'b0;
   logic [4:0]  flags_i = '0;
   logic [63:0] stat_i = '0;
   logic [63:0] pc_i = '0;
   logic [63:0] npc_i = '0;
   logic [63:0] stat_o;
   logic        trap_o;
   logic [63:0] pc_o;
   logic [63:0] npc_o;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam logic [63:0] UPPER = 64'h3C00_0F00_F000_8000;

   always #2.5 clk = ~clk;

   fpx_recorder u_fpx_recorder (
      .clk(clk), .rst_n(rst_n), .rec_valid_i(rec_valid_i), .flags_i(flags_i),
      .stat_i(stat_i), .pc_i(pc_i), .npc_i(npc_i),
      .stat_o(stat_o), .trap_o(trap_o), .pc_o(pc_o), .npc_o(npc_o)
   );

   function automatic logic [63:0] mk(input logic [4:0] ena, input logic ttyp,
                                      input logic [4:0] hist, input logic [4:0] cur);
      return UPPER | (64'(ena) << 23) | (64'(ttyp) << 14) | (64'(hist) << 5) | 64'(cur);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [4:0] fl, input logic [63:0] st,
                        input logic [63:0] pc, input logic [63:0] npc);
      @(negedge clk);
      flags_i = fl; stat_i = st; pc_i = pc; npc_i = npc; rec_valid_i = 1'b1;
      @(negedge clk);
      rec_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 stat", stat_o, 64'd0);
      chk("R1 trap", 64'(trap_o), 64'd0);
      chk("R1 pc", pc_o, 64'd0);
      chk("R1 npc", npc_o, 64'd0);
   endtask

   task automatic t_no_exc();
      apply(5'b0, mk(5'b0, 1'b0, 5'b00011, 5'b11111), 64'h1000, 64'h1004);
      chk("R7 stat", stat_o, mk(5'b0, 1'b0, 5'b00011, 5'b0));
      chk("R7 trap", 64'(trap_o), 64'd0);
      chk("R7 pc", pc_o, 64'h1004);
      chk("R7 npc", npc_o, 64'h1008);
   endtask

   task automatic t_accrue();
      apply(5'b10101, mk(5'b0, 1'b0, 5'b00010, 5'b0), 64'h2000, 64'h2004);
      chk("R4 stat", stat_o, mk(5'b0, 1'b0, 5'b10111, 5'b10101));
      chk("R2 no trap", 64'(trap_o), 64'd0);
      chk("R6 pc adv", pc_o, 64'h2004);
      chk("R6 npc adv", npc_o, 64'h2008);
   endtask

   task automatic t_trap_single();
      apply(5'b01000, mk(5'b01000, 1'b0, 5'b00001, 5'b0), 64'h3000, 64'h3004);
      chk("R5 stat", stat_o, mk(5'b01000, 1'b1, 5'b00001, 5'b01000));
      chk("R2 trap", 64'(trap_o), 64'd1);
      chk("R6 pc hold", pc_o, 64'h3000);
      chk("R6 npc hold", npc_o, 64'h3004);
   endtask

   task automatic t_priority();
      apply(5'b11111, mk(5'b11111, 1'b0, 5'b0, 5'b0), 64'h10, 64'h14);
      chk("R3 nv wins", stat_o, mk(5'b11111, 1'b1, 5'b0, 5'b10000));
      apply(5'b01110, mk(5'b11111, 1'b0, 5'b0, 5'b0), 64'h10, 64'h14);
      chk("R3 of wins", stat_o, mk(5'b11111, 1'b1, 5'b0, 5'b01000));
      apply(5'b00110, mk(5'b11111, 1'b0, 5'b0, 5'b0), 64'h10, 64'h14);
      chk("R3 uf wins", stat_o, mk(5'b11111, 1'b1, 5'b0, 5'b00100));
      apply(5'b00011, mk(5'b11111, 1'b0, 5'b0, 5'b0), 64'h10, 64'h14);
      chk("R3 dz wins", stat_o, mk(5'b11111, 1'b1, 5'b0, 5'b00010));
   endtask

   task automatic t_masked_mix();
      apply(5'b11111, mk(5'b00011, 1'b0, 5'b01000, 5'b0), 64'h4000, 64'h4004);
      chk("R3 masked cause", stat_o, mk(5'b00011, 1'b1, 5'b01000, 5'b00010));
      chk("R2 masked trap", 64'(trap_o), 64'd1);
      chk("R6 masked hold", pc_o, 64'h4000);
      apply(5'b11100, mk(5'b00011, 1'b0, 5'b01000, 5'b0), 64'h4000, 64'h4004);
      chk("R4 disabled accrue", stat_o, mk(5'b00011, 1'b0, 5'b11100, 5'b11100));
      chk("R2 disabled no trap", 64'(trap_o), 64'd0);
      chk("R6 disabled adv", pc_o, 64'h4004);
   endtask

   task automatic t_hold();
      apply(5'b00001, mk(5'b0, 1'b1, 5'b0, 5'b0), 64'h5000, 64'h5004);
      chk("R8 ttyp kept", stat_o, mk(5'b0, 1'b1, 5'b00001, 5'b00001));
      @(negedge clk);
      flags_i = 5'b11111; stat_i = '1; pc_i = 64'hDEAD; npc_i = 64'hBEEF;
      repeat (3) @(negedge clk);
      chk("R9 stat", stat_o, mk(5'b0, 1'b1, 5'b00001, 5'b00001));
      chk("R9 trap", 64'(trap_o), 64'd0);
      chk("R9 pc", pc_o, 64'h5004);
      chk("R9 npc", npc_o, 64'h5008);
   endtask

   task automatic t_wrap();
      apply(5'b0, 64'hFFFF_FFFF_F07F_BC00, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC);
      chk("R8 upper bits", stat_o, 64'hFFFF_FFFF_F07F_BC00);
      chk("R6 wrap pc", pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
      chk("R6 wrap npc", npc_o, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_no_exc();
      t_accrue();
      t_trap_single();
      t_priority();
      t_masked_mix();
      t_hold();
      t_wrap();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule